// File: doc/BRIEF.md
# Dual-Phase Sample Stream Merger with Gain and Offset Correction

Two converters sample the same analog input on opposite edges of one sampling clock. In the fabric clock domain each delivers one 12-bit two's complement sample per cycle, with its own valid strobe. This block puts each converter's sample through its own correction path and packs the two results into one output word. The correction adds a small signed offset trim and then multiplies by an unsigned fixed-point gain. The output word holds two samples per fabric cycle, in time order, at twice the per-converter rate.

The coarse offset is set in the analog domain ahead of the converters. The offset here only trims what is left over, and the gain term removes the gain mismatch between the two converters. Each converter has its own gain and offset inputs, driven from a register interface. The block samples these coefficients in the same cycle as the sample pair they apply to. A new value therefore takes effect on the next pair the block accepts.

Top module: `tiadc_merge`

## Requirements
- R1: While reset is asserted and after its release until a pair has passed through, `merged_valid` is 0 and `merged_data` is all zeros.
- R2: The block accepts a pair only in a cycle where `a_valid` and `b_valid` are both 1. The corrected pair then appears with `merged_valid` high exactly 3 fabric cycles later.
- R3: A cycle where only one of `a_valid` and `b_valid` is 1 produces no output. The lone sample is discarded, and `merged_valid` stays 0 for the cycle that pair would have occupied.
- R4: `merged_data[11:0]` carries the corrected sample from converter A (0 degrees, earlier in time). `merged_data[23:12]` carries the corrected sample from converter B (180 degrees).
- R5: Each corrected sample equals (sample + offset) × gain / 2^14. The sample and the 8-bit offset are two's complement. The gain is a 16-bit unsigned value with 14 fractional bits, so 0x4000 is unity.
- R6: The block rounds to nearest, with exact halves rounded toward positive infinity: it adds 2^13 and then takes the floor of the division by 2^14. For example, 0.5 becomes 1, −0.5 becomes 0, 1.5 becomes 2 and −1.5 becomes −1.
- R7: Results above 2047 give 2047 (0x7FF), and results below −2048 give −2048 (0x800).
- R8: Each pair uses the gain and offset values present at the ports in its acceptance cycle. A's coefficients affect only the A result, and B's only the B result. Coefficients may change every cycle.
- R9: While `merged_valid` is 0, `merged_data` keeps the last pair that was output.
- R10: With gain 0x4000 and offset 0, a converter's output sample equals its input sample bit for bit, across the full range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sample | input | 12 | Converter A sample, two's complement |
| a_valid | input | 1 | Converter A sample strobe |
| b_sample | input | 12 | Converter B sample, two's complement |
| b_valid | input | 1 | Converter B sample strobe |
| a_gain | input | 16 | Converter A gain, unsigned, 14 fractional bits |
| b_gain | input | 16 | Converter B gain, unsigned, 14 fractional bits |
| a_offset | input | 8 | Converter A residual offset, two's complement |
| b_offset | input | 8 | Converter B residual offset, two's complement |
| merged_data | output | 24 | Corrected pair, A in the low half, B in the high half |
| merged_valid | output | 1 | Pair present on merged_data |

## Verification
The hardest behaviour to reach from the ports is the pairing of coefficients with samples. A coefficient value that is only one cycle early or late still gives plausible numbers whenever it stays constant. The stimulus therefore changes the gain and offset of both converters on every cycle, gives A and B different values, and mixes in cycles with lone or missing strobes. A misaligned coefficient register or a lane swap then changes the result. Directed pairs also place the rounding exactly on halves of both signs, and drive both saturation limits with maximum gain and an extreme offset.

// File: rtl/tiadc_pkg.sv
package tiadc_pkg;

    localparam int NLANE         = 2;
    localparam int LANE_A        = 0;
    localparam int LANE_B        = 1;
    localparam int PIPE_DEPTH    = 3;

    localparam int DEF_SAMPLE_W  = 12;
    localparam int DEF_GAIN_W    = 16;
    localparam int DEF_GAIN_FRAC = 14;
    localparam int DEF_OFFS_W    = 8;

    typedef struct packed {
        logic [PIPE_DEPTH-1:0] vld;
    } merge_state_t;

endpackage

// File: rtl/tiadc_round_sat.sv
module tiadc_round_sat #(
    parameter int PROD_W    = 30,
    parameter int GAIN_FRAC = tiadc_pkg::DEF_GAIN_FRAC,
    parameter int SAMPLE_W  = tiadc_pkg::DEF_SAMPLE_W
) (
    input  logic [PROD_W-1:0]   prod,
    output logic [SAMPLE_W-1:0] result
);
    localparam int RND_W = PROD_W + 1;
    localparam logic signed [RND_W-1:0] HALF = RND_W'(1) << (GAIN_FRAC - 1);
    localparam logic signed [RND_W-1:0] MAXV = (RND_W'(1) << (SAMPLE_W - 1)) - RND_W'(1);
    localparam logic signed [RND_W-1:0] MINV = -(RND_W'(1) << (SAMPLE_W - 1));

    logic signed [RND_W-1:0] rnd;
    logic signed [RND_W-1:0] scaled;

    always_comb begin
        rnd    = $signed({prod[PROD_W-1], prod}) + HALF;
        scaled = rnd >>> GAIN_FRAC;
        if (scaled > MAXV)
            result = MAXV[SAMPLE_W-1:0];
        else if (scaled < MINV)
            result = MINV[SAMPLE_W-1:0];
        else
            result = scaled[SAMPLE_W-1:0];
    end

endmodule

// File: rtl/tiadc_lane.sv
module tiadc_lane #(
    parameter int SAMPLE_W  = tiadc_pkg::DEF_SAMPLE_W,
    parameter int GAIN_W    = tiadc_pkg::DEF_GAIN_W,
    parameter int GAIN_FRAC = tiadc_pkg::DEF_GAIN_FRAC,
    parameter int OFFS_W    = tiadc_pkg::DEF_OFFS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          stage_en,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [GAIN_W-1:0]   gain,
    input  logic [OFFS_W-1:0]   offs,
    output logic [SAMPLE_W-1:0] corr
);
    localparam int SUM_W  = ((SAMPLE_W > OFFS_W) ? SAMPLE_W : OFFS_W) + 1;
    localparam int PROD_W = SUM_W + GAIN_W + 1;
    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << GAIN_FRAC;

    typedef struct packed {
        logic [SUM_W-1:0]    sum;
        logic [GAIN_W-1:0]   gain;
        logic [PROD_W-1:0]   prod;
        logic [SAMPLE_W-1:0] corr;
    } lane_state_t;

    lane_state_t st_d, st_q;
    logic [SAMPLE_W-1:0] rs_out;

    tiadc_round_sat #(
        .PROD_W    (PROD_W),
        .GAIN_FRAC (GAIN_FRAC),
        .SAMPLE_W  (SAMPLE_W)
    ) i_round_sat (
        .prod   (st_q.prod),
        .result (rs_out)
    );

    always_comb begin
        st_d = st_q;
        if (stage_en[0]) begin
            st_d.sum  = SUM_W'($signed(sample)) + SUM_W'($signed(offs));
            st_d.gain = gain;
        end
        if (stage_en[1]) begin
            st_d.prod = PROD_W'($signed(st_q.sum))
                      * $signed({{(PROD_W-GAIN_W){1'b0}}, st_q.gain});
        end
        if (stage_en[2]) begin
            st_d.corr = rs_out;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign corr = st_q.corr;

    // R10: unity gain and zero trim pass a sample through unchanged
    assert_unity_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_en[0] && gain == UNITY && offs == '0) |=> ##2 (corr == $past(sample, 3)));

endmodule

// File: rtl/tiadc_merge.sv
module tiadc_merge
    import tiadc_pkg::*;
#(
    parameter int SAMPLE_W  = DEF_SAMPLE_W,
    parameter int GAIN_W    = DEF_GAIN_W,
    parameter int GAIN_FRAC = DEF_GAIN_FRAC,
    parameter int OFFS_W    = DEF_OFFS_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SAMPLE_W-1:0]       a_sample,
    input  logic                      a_valid,
    input  logic [SAMPLE_W-1:0]       b_sample,
    input  logic                      b_valid,
    input  logic [GAIN_W-1:0]         a_gain,
    input  logic [GAIN_W-1:0]         b_gain,
    input  logic [OFFS_W-1:0]         a_offset,
    input  logic [OFFS_W-1:0]         b_offset,
    output logic [NLANE*SAMPLE_W-1:0] merged_data,
    output logic                      merged_valid
);
    merge_state_t st_d, st_q;
    logic         pair_ok;

    logic [SAMPLE_W-1:0] lane_smp  [NLANE];
    logic [GAIN_W-1:0]   lane_gain [NLANE];
    logic [OFFS_W-1:0]   lane_offs [NLANE];
    logic [SAMPLE_W-1:0] lane_corr [NLANE];

    assign pair_ok = a_valid & b_valid;

    assign lane_smp[LANE_A]  = a_sample;
    assign lane_smp[LANE_B]  = b_sample;
    assign lane_gain[LANE_A] = a_gain;
    assign lane_gain[LANE_B] = b_gain;
    assign lane_offs[LANE_A] = a_offset;
    assign lane_offs[LANE_B] = b_offset;

    always_comb begin
        st_d     = st_q;
        st_d.vld = {st_q.vld[PIPE_DEPTH-2:0], pair_ok};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        tiadc_lane #(
            .SAMPLE_W  (SAMPLE_W),
            .GAIN_W    (GAIN_W),
            .GAIN_FRAC (GAIN_FRAC),
            .OFFS_W    (OFFS_W)
        ) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .stage_en ({st_q.vld[1:0], pair_ok}),
            .sample   (lane_smp[g]),
            .gain     (lane_gain[g]),
            .offs     (lane_offs[g]),
            .corr     (lane_corr[g])
        );
        assign merged_data[g*SAMPLE_W +: SAMPLE_W] = lane_corr[g];
    end

    assign merged_valid = st_q.vld[PIPE_DEPTH-1];

    // R2: an accepted pair emerges three cycles later
    assert_pair_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && b_valid) |=> ##2 merged_valid);

    // R3: a lone strobe yields no output slot
    assert_lone_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid != b_valid) |=> ##2 !merged_valid);

    // R9: output word holds when no pair is finishing
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.vld[1] |=> $stable(merged_data));

endmodule

// File: tb/test_tiadc_merge.sv
module test_tiadc_merge;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit          v;
        bit          lone;
        logic [23:0] d;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] a_sample, b_sample;
    logic        a_valid, b_valid;
    logic [15:0] a_gain, b_gain;
    logic [7:0]  a_offset, b_offset;
    logic [23:0] merged_data;
    logic        merged_valid;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    exp_t q[$];
    logic [23:0] last_d = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tiadc_merge i_tiadc_merge (
        .clk          (clk),
        .rst_n        (rst_n),
        .a_sample     (a_sample),
        .a_valid      (a_valid),
        .b_sample     (b_sample),
        .b_valid      (b_valid),
        .a_gain       (a_gain),
        .b_gain       (b_gain),
        .a_offset     (a_offset),
        .b_offset     (b_offset),
        .merged_data  (merged_data),
        .merged_valid (merged_valid)
    );

    function automatic logic [11:0] ref_corr(logic [11:0] s, logic [7:0] o, logic [15:0] g);
        longint p;
        longint r;
        p = (longint'($signed(s)) + longint'($signed(o))) * longint'({1'b0, g});
        r = (p + 8192) >>> 14;
        if (r > 2047)  r = 2047;
        if (r < -2048) r = -2048;
        return 12'(r);
    endfunction

    task automatic compare_front();
        exp_t        e;
        logic [23:0] want;
        string       vtag;
        e    = q.pop_front();
        vtag = e.lone ? "R3" : "R2";
        checks++;
        if (merged_valid !== e.v) begin
            errors++;
            $display("FAIL %s valid actual %0b expected %0b", vtag, merged_valid, e.v);
        end
        if (e.v) begin
            want   = e.d;
            last_d = e.d;
        end else begin
            want = last_d;
        end
        checks++;
        if (merged_data !== want) begin
            errors++;
            $display("FAIL %s data actual %h expected %h", e.v ? e.tag : "R9", merged_data, want);
        end
    endtask

    task automatic step(bit av, bit bv, logic [11:0] sa, logic [11:0] sb,
                        logic [15:0] ga, logic [15:0] gb, logic [7:0] oa, logic [7:0] ob,
                        string tag);
        exp_t e;
        a_valid = av; b_valid = bv; a_sample = sa; b_sample = sb;
        a_gain = ga; b_gain = gb; a_offset = oa; b_offset = ob;
        e.v    = av && bv;
        e.lone = av != bv;
        e.d    = {ref_corr(sb, ob, gb), ref_corr(sa, oa, ga)};
        e.tag  = tag;
        q.push_back(e);
        @(negedge clk);
        compare_front();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++)
            step(0, 0, 12'h0, 12'h0, 16'h4000, 16'h4000, 8'h0, 8'h0, "R9");
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        exp_t pre;
        rst_n = 0;
        a_valid = 0; b_valid = 0; a_sample = '0; b_sample = '0;
        a_gain = 16'h4000; b_gain = 16'h4000; a_offset = '0; b_offset = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if (merged_valid !== 1'b0 || merged_data !== 24'h0) begin
            errors++;
            $display("FAIL R1 reset actual %0b/%h expected 0/000000", merged_valid, merged_data);
        end
        rst_n = 1;
        pre.v = 0; pre.lone = 0; pre.d = '0; pre.tag = "R1";
        q.push_back(pre);
        q.push_back(pre);

        // R10: unity passthrough over the range
        step(1, 1, 12'h000, 12'h7FF, 16'h4000, 16'h4000, 8'h00, 8'h00, "R10");
        step(1, 1, 12'h800, 12'h07B, 16'h4000, 16'h4000, 8'h00, 8'h00, "R10");
        step(1, 1, 12'hFFB, 12'h001, 16'h4000, 16'h4000, 8'h00, 8'h00, "R10");
        // R4: distinct A and B values show lane order
        step(1, 1, 12'h111, 12'h222, 16'h4000, 16'h4000, 8'h00, 8'h00, "R4");
        // R5: gain and offset arithmetic
        step(1, 1, 12'h064, 12'h064, 16'h6000, 16'h3000, 8'h0A, 8'hEC, "R5");
        step(1, 1, 12'hF38, 12'h3E8, 16'h6000, 16'h3000, 8'h0A, 8'hEC, "R5");
        // R6: halves of both signs
        step(1, 1, 12'h001, 12'hFFF, 16'h2000, 16'h2000, 8'h00, 8'h00, "R6");
        step(1, 1, 12'h003, 12'hFFD, 16'h2000, 16'h2000, 8'h00, 8'h00, "R6");
        step(1, 1, 12'h000, 12'h000, 16'h2000, 16'h2000, 8'h01, 8'hFF, "R6");
        // R7: both saturation limits
        step(1, 1, 12'h7FF, 12'h800, 16'hFFFF, 16'hFFFF, 8'h7F, 8'h80, "R7");
        step(1, 1, 12'h800, 12'h7FF, 16'hFFFF, 16'hFFFF, 8'h80, 8'h7F, "R7");
        step(1, 1, 12'h7F0, 12'h810, 16'h4000, 16'h4000, 8'h7F, 8'h80, "R7");
        // R9: idle gap holds last pair
        idle(4);
        // R3: lone strobes dropped
        step(1, 0, 12'h555, 12'h0AA, 16'h4000, 16'h4000, 8'h00, 8'h00, "R3");
        step(0, 1, 12'h0AA, 12'h555, 16'h4000, 16'h4000, 8'h00, 8'h00, "R3");
        step(1, 1, 12'h012, 12'h034, 16'h4000, 16'h4000, 8'h00, 8'h00, "R3");
        step(0, 1, 12'h700, 12'h700, 16'h4000, 16'h4000, 8'h00, 8'h00, "R3");
        idle(3);
        // R8: coefficients switch every cycle, per converter
        for (int i = 0; i < 40; i++) begin
            step(1, 1, 12'(i * 37), 12'(-i * 53),
                 16'(16'h3800 + i * 97), 16'(16'h4800 - i * 61),
                 8'(i * 5 - 100), 8'(60 - i * 7), "R8");
        end
        // R5: mixed random traffic
        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            r = $urandom % 8;
            step(r != 0 && r != 1, r != 0 && r != 2, 12'($urandom), 12'($urandom),
                 16'($urandom), 16'($urandom), 8'($urandom), 8'($urandom), "R5");
        end
        idle(5);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule